// File: doc/BRIEF.md
# Mixed-Width Bit-Accounted FIFO

This block is a single-clock FIFO whose write and read ports may carry different word widths, for example two-bit words in and four-bit words out. Occupancy is not kept in words. It is kept in data bits, using two 12-bit bit-address counters, one for writes and one for reads. Each accepted operation advances its counter by the number of bits its word accounts for. Words whose width is a multiple of nine are stored as 9-bit lanes. Each such lane counts as eight bits, so the 12-bit counters still cover 4096 accounted bits.

Full and empty are decided at word granularity for the port concerned. Empty holds while fewer bits than one read word are stored. Full holds while less room than one write word is free. Almost-full and almost-empty compare the stored bit count with two programmable 12-bit thresholds, also given in bits. Two stop inputs select the behaviour at each boundary. When a stop input is high, an operation at that boundary is refused. When it is low, the counter keeps running, so contents already written can be read again as the read counter circles the array.

The read port is show-ahead: `rd_data` always presents the word at the read counter, and asserting `rd_en` moves the counter past it.

Top module: `mixw_fifo`

## Requirements
- R1: An accepted write advances `wr_ptr` by the write word's accounted bits, and an accepted read advances `rd_ptr` by the read word's accounted bits. A word of W bits accounts for W bits, except that a width divisible by nine accounts for eight bits per 9-bit lane (9 -> 8, 18 -> 16).
- R2: Both counters start at 0 and return to 0 when they reach CAP_BITS (256 by default), instead of reaching CAP_BITS.
- R3: `empty` is high exactly while the stored bit count is less than one read word's accounted bits. With a 2-bit write port and a 4-bit read port, one write leaves `empty` high.
- R4: `full` is high exactly while CAP_BITS minus the stored bit count is less than one write word's accounted bits.
- R5: `almost_full` is high exactly while the stored bit count is greater than or equal to `af_thr`.
- R6: `almost_empty` is high exactly while the stored bit count is less than or equal to `ae_thr`.
- R7: While `stop_on_full` is high, a write attempted while `full` is high changes neither `wr_ptr`, nor the stored data, nor the flags.
- R8: While `stop_on_empty` is high, a read attempted while `empty` is high leaves `rd_ptr` and the flags unchanged.
- R9: While a stop input is low, its counter keeps advancing past the boundary. The stored bit count then clamps at 0 on reads and at CAP_BITS on writes, and earlier written words are presented again when the read counter comes back round to them.
- R10: `rd_data` shows the word that starts at `rd_ptr`. Bits written earlier occupy the less significant positions of a read word, and bit 0 of a write word is the earliest of its bits.
- R11: A synchronous active-high `rst` clears both counters and the stored bit count. The flags then take their values for zero occupancy: `empty` high, `full` low, and the almost flags set by their thresholds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | WR_W | Write word |
| rd_en | input | 1 | Read request (advances past the shown word) |
| rd_data | output | RD_W | Word at the read counter |
| af_thr | input | 12 | Almost-full threshold in bits |
| ae_thr | input | 12 | Almost-empty threshold in bits |
| stop_on_full | input | 1 | Refuse writes while full |
| stop_on_empty | input | 1 | Refuse reads while empty |
| wr_ptr | output | 12 | Write bit-address counter |
| rd_ptr | output | 12 | Read bit-address counter |
| full | output | 1 | Less than one write word free |
| empty | output | 1 | Less than one read word stored |
| almost_full | output | 1 | Stored bits at or above `af_thr` |
| almost_empty | output | 1 | Stored bits at or below `ae_thr` |

## Verification
On every cycle the assertions check the following: counters stay below capacity and stay aligned to their step; a counter holds when its operation is not accepted; refused writes and refused reads leave their counter frozen; the stored bit count clamps at both ends; and the first lane of a write lands in the array. The bench scenarios show the rest. These are the per-port word-granular empty decision, the wrap of a counter back through zero after a full lap, the re-reading of earlier data with the empty stop released, and the ordering of narrow writes inside a wide read word. Randomized traffic with changing thresholds and stop settings compares every flag and the read word against a bit-level model of the array.

// File: rtl/mixw_fifo_pkg.sv
package mixw_fifo_pkg;

  localparam int PTR_W = 12;
  localparam int LVL_W = PTR_W + 1;

  // physical bits per storage lane for a port of width w
  function automatic int lane_phys(input int w);
    return (w % 9 == 0) ? 9 : 1;
  endfunction

  // accounted bits per storage lane for a port of width w
  function automatic int lane_acct(input int w);
    return (w % 9 == 0) ? 8 : 1;
  endfunction

  // accounted bits for one whole word of width w
  function automatic int acct_bits(input int w);
    return (w / lane_phys(w)) * lane_acct(w);
  endfunction

  // next stored bit count, clamped into [0, cap]
  function automatic int clamp_level(input int cur, input int add,
                                     input int sub, input int cap);
    int t;
    t = cur + add - sub;
    if (t < 0) t = 0;
    else if (t > cap) t = cap;
    return t;
  endfunction

endpackage

// File: rtl/mixw_ptr.sv
module mixw_ptr
  import mixw_fifo_pkg::*;
#(
  parameter int CAP_BITS = 256,
  parameter int STEP     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr
);

  localparam logic [PTR_W:0] CAP_W  = (PTR_W+1)'(CAP_BITS);
  localparam logic [PTR_W:0] STEP_W = (PTR_W+1)'(STEP);

  logic [PTR_W:0]   sum;
  logic [PTR_W-1:0] ptr_nxt;

  always_comb begin
    sum = {1'b0, ptr} + STEP_W;
    if (sum >= CAP_W) ptr_nxt = PTR_W'(sum - CAP_W);
    else              ptr_nxt = sum[PTR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)      ptr <= '0;
    else if (adv) ptr <= ptr_nxt;
  end

  // R2
  range_chk: assert property (@(posedge clk) disable iff (rst)
    {1'b0, ptr} < CAP_W);

  // R1
  align_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(ptr) % STEP) == 0);

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ptr));

endmodule

// File: rtl/mixw_level.sv
module mixw_level
  import mixw_fifo_pkg::*;
#(
  parameter int CAP_BITS = 256,
  parameter int WR_ACCT  = 2,
  parameter int RD_ACCT  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_acc,
  input  logic             rd_acc,
  input  logic [PTR_W-1:0] af_thr,
  input  logic [PTR_W-1:0] ae_thr,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             almost_full,
  output logic             almost_empty
);

  localparam logic [LVL_W-1:0] CAP_L = LVL_W'(CAP_BITS);
  localparam logic [LVL_W-1:0] WR_L  = LVL_W'(WR_ACCT);
  localparam logic [LVL_W-1:0] RD_L  = LVL_W'(RD_ACCT);

  logic [LVL_W-1:0] level_nxt;
  logic [LVL_W-1:0] free_bits;

  always_comb begin
    level_nxt = LVL_W'(clamp_level(int'(level),
                                   wr_acc ? WR_ACCT : 0,
                                   rd_acc ? RD_ACCT : 0,
                                   CAP_BITS));
  end

  always_ff @(posedge clk) begin
    if (rst) level <= '0;
    else     level <= level_nxt;
  end

  always_comb begin
    free_bits    = CAP_L - level;
    full         = free_bits < WR_L;
    empty        = level < RD_L;
    almost_full  = level >= {1'b0, af_thr};
    almost_empty = level <= {1'b0, ae_thr};
  end

  // R9
  bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= CAP_L);

  // R9
  clamp_low_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && !wr_acc && empty) |=> (level == '0));

  // R9
  clamp_high_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && !rd_acc && full) |=> (level == CAP_L));

endmodule

// File: rtl/mixw_lanes.sv
module mixw_lanes
  import mixw_fifo_pkg::*;
#(
  parameter int CAP_BITS = 256,
  parameter int WR_W     = 2,
  parameter int RD_W     = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [WR_W-1:0]  wr_data,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [RD_W-1:0]  rd_data
);

  localparam int LP    = lane_phys(WR_W);
  localparam int LA    = lane_acct(WR_W);
  localparam int NL    = CAP_BITS / LA;
  localparam int WL    = WR_W / LP;
  localparam int RL    = RD_W / LP;
  localparam int IDX_W = (NL > 1) ? $clog2(NL) : 1;

  logic [LP-1:0]    mem [NL];
  logic [IDX_W-1:0] wbase;
  logic [IDX_W-1:0] rbase;

  assign wbase = IDX_W'(wr_ptr / PTR_W'(LA));
  assign rbase = IDX_W'(rd_ptr / PTR_W'(LA));

  always_ff @(posedge clk) begin
    if (we) begin
      for (int j = 0; j < WL; j++) begin
        mem[wbase + IDX_W'(j)] <= wr_data[j*LP +: LP];
      end
    end
  end

  for (genvar k = 0; k < RL; k++) begin : g_rd_lane
    assign rd_data[k*LP +: LP] = mem[rbase + IDX_W'(k)];
  end

  // R10
  lane0_chk: assert property (@(posedge clk)
    we |=> (mem[$past(wbase)] == $past(wr_data[LP-1:0])));

endmodule

// File: rtl/mixw_fifo.sv
module mixw_fifo
  import mixw_fifo_pkg::*;
#(
  parameter int WR_W     = 2,
  parameter int RD_W     = 4,
  parameter int CAP_BITS = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WR_W-1:0]  wr_data,
  input  logic             rd_en,
  output logic [RD_W-1:0]  rd_data,
  input  logic [PTR_W-1:0] af_thr,
  input  logic [PTR_W-1:0] ae_thr,
  input  logic             stop_on_full,
  input  logic             stop_on_empty,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             full,
  output logic             empty,
  output logic             almost_full,
  output logic             almost_empty
);

  localparam int WR_ACCT = acct_bits(WR_W);
  localparam int RD_ACCT = acct_bits(RD_W);

  logic             wr_blocked;
  logic             rd_blocked;
  logic             wr_acc;
  logic             rd_acc;
  logic [LVL_W-1:0] level;

  assign wr_blocked = full && stop_on_full;
  assign rd_blocked = empty && stop_on_empty;
  assign wr_acc     = wr_en && !wr_blocked;
  assign rd_acc     = rd_en && !rd_blocked;

  mixw_ptr #(.CAP_BITS(CAP_BITS), .STEP(WR_ACCT)) u_wptr (
    .clk(clk), .rst(rst), .adv(wr_acc), .ptr(wr_ptr)
  );

  mixw_ptr #(.CAP_BITS(CAP_BITS), .STEP(RD_ACCT)) u_rptr (
    .clk(clk), .rst(rst), .adv(rd_acc), .ptr(rd_ptr)
  );

  mixw_level #(.CAP_BITS(CAP_BITS), .WR_ACCT(WR_ACCT), .RD_ACCT(RD_ACCT)) u_level (
    .clk(clk), .rst(rst), .wr_acc(wr_acc), .rd_acc(rd_acc),
    .af_thr(af_thr), .ae_thr(ae_thr), .level(level),
    .full(full), .empty(empty),
    .almost_full(almost_full), .almost_empty(almost_empty)
  );

  mixw_lanes #(.CAP_BITS(CAP_BITS), .WR_W(WR_W), .RD_W(RD_W)) u_lanes (
    .clk(clk), .we(wr_acc), .wr_ptr(wr_ptr), .wr_data(wr_data),
    .rd_ptr(rd_ptr), .rd_data(rd_data)
  );

  // R7
  wr_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_blocked) |=> $stable(wr_ptr));

  // R8
  rd_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_blocked) |=> $stable(rd_ptr));

  // R7
  wr_refuse_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_blocked && !rd_en) |=> (full && $stable(level)));

  // R3
  drain_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && !wr_acc && level == LVL_W'(RD_ACCT)) |=> empty);

endmodule

// File: tb/mixw_fifo_tb_top.sv
module mixw_fifo_tb_top;

  localparam int WR_W = 2;
  localparam int RD_W = 4;
  localparam int CAP  = 256;

  // bits a word accounts for: one bit dropped per nine
  function automatic int acct(input int w);
    return w - (w / 9);
  endfunction

  localparam int WA = acct(WR_W);
  localparam int RA = acct(RD_W);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic            wr_en = 1'b0, rd_en = 1'b0;
  logic [WR_W-1:0] wr_data = '0;
  logic [RD_W-1:0] rd_data;
  logic [11:0]     af_thr = 12'd100, ae_thr = 12'd10;
  logic            sof = 1'b1, soe = 1'b1;
  logic [11:0]     wr_ptr, rd_ptr;
  logic            full, empty, almost_full, almost_empty;

  mixw_fifo #(.WR_W(WR_W), .RD_W(RD_W), .CAP_BITS(CAP)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .af_thr(af_thr), .ae_thr(ae_thr),
    .stop_on_full(sof), .stop_on_empty(soe),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full(full), .empty(empty),
    .almost_full(almost_full), .almost_empty(almost_empty)
  );

  bit mbits  [CAP];
  bit mknown [CAP];
  int mw, mr, mlvl;
  int n_chk, n_fail;
  bit done;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int  exp_rd;
    bit  known;
    check(int'(wr_ptr) == mw, "R1/R2 wr_ptr", int'(wr_ptr), mw);
    check(int'(rd_ptr) == mr, "R1/R2 rd_ptr", int'(rd_ptr), mr);
    check(empty == (mlvl < RA), "R3 empty", int'(empty), int'(mlvl < RA));
    check(full == ((CAP - mlvl) < WA), "R4 full", int'(full), int'((CAP - mlvl) < WA));
    check(almost_full == (mlvl >= int'(af_thr)), "R5 almost_full",
          int'(almost_full), int'(mlvl >= int'(af_thr)));
    check(almost_empty == (mlvl <= int'(ae_thr)), "R6 almost_empty",
          int'(almost_empty), int'(mlvl <= int'(ae_thr)));
    exp_rd = 0;
    known  = 1'b1;
    for (int j = 0; j < RD_W; j++) begin
      if (!mknown[(mr + j) % CAP]) known = 1'b0;
      exp_rd |= int'(mbits[(mr + j) % CAP]) << j;
    end
    if (known) check(int'(rd_data) == exp_rd, "R10 rd_data", int'(rd_data), exp_rd);
  endtask

  task automatic step(input bit we, input logic [WR_W-1:0] wd, input bit re);
    bit full_m, empty_m, wacc, racc;
    int t;
    @(negedge clk);
    wr_en   = we;
    wr_data = wd;
    rd_en   = re;
    full_m  = (CAP - mlvl) < WA;
    empty_m = mlvl < RA;
    wacc    = we && !(full_m && sof);
    racc    = re && !(empty_m && soe);
    @(posedge clk);
    if (rst) begin
      mw = 0; mr = 0; mlvl = 0;
    end else begin
      if (wacc) begin
        for (int j = 0; j < WR_W; j++) begin
          mbits[(mw + j) % CAP]  = wd[j];
          mknown[(mw + j) % CAP] = 1'b1;
        end
        mw = (mw + WA) % CAP;
      end
      if (racc) mr = (mr + RA) % CAP;
      t = mlvl + (wacc ? WA : 0) - (racc ? RA : 0);
      if (t < 0) t = 0;
      if (t > CAP) t = CAP;
      mlvl = t;
    end
    #1;
    compare_all();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int p;
    void'($urandom(32'd4242));
    // R11 reset state
    do_reset();
    check(wr_ptr == 12'd0 && rd_ptr == 12'd0, "R11 counters", int'(wr_ptr), 0);
    check(empty && !full, "R11 empty/full", int'({empty, full}), 2);
    check(!almost_full && almost_empty, "R11 almost flags",
          int'({almost_full, almost_empty}), 1);

    // R3 one narrow write does not make a whole read word
    step(1'b1, 2'b01, 1'b0);
    check(empty == 1'b1, "R3 one write still empty", int'(empty), 1);
    step(1'b1, 2'b10, 1'b0);
    check(empty == 1'b0, "R3 two writes not empty", int'(empty), 0);
    // R10 first write in low bits
    check(rd_data == 4'b1001, "R10 ordering", int'(rd_data), 9);
    step(1'b0, '0, 1'b1);

    // R8 read refused when empty with stop high
    soe = 1'b1;
    step(1'b0, '0, 1'b1);
    check(rd_ptr == 12'd4, "R8 rd_ptr frozen", int'(rd_ptr), 4);

    // fill to full, wrapping the write counter
    sof = 1'b1;
    for (int i = 0; i < CAP / WA; i++) step(1'b1, 2'(i), 1'b0);
    check(full == 1'b1, "R4 full after fill", int'(full), 1);
    check(wr_ptr == 12'd4, "R2 write counter wrapped", int'(wr_ptr), 4);
    step(1'b1, 2'b11, 1'b0);
    check(wr_ptr == 12'd4, "R7 wr_ptr frozen", int'(wr_ptr), 4);
    check(full == 1'b1, "R7 still full", int'(full), 1);
    // one read makes room again
    step(1'b0, '0, 1'b1);
    check(full == 1'b0, "R4 room after read", int'(full), 0);
    // R9 writes pass full with stop low
    sof = 1'b0;
    step(1'b1, 2'b01, 1'b0);
    step(1'b1, 2'b01, 1'b0);
    step(1'b1, 2'b10, 1'b0);
    check(wr_ptr == 12'd10, "R9 wr_ptr passes full", int'(wr_ptr), 10);
    check(full == 1'b1, "R9 full clamps", int'(full), 1);
    sof = 1'b1;
    for (int i = 0; i < CAP / RA; i++) step(1'b0, '0, 1'b1);

    // R9 re-read with empty stop released
    do_reset();
    soe = 1'b0;
    step(1'b1, 2'b10, 1'b0);
    step(1'b1, 2'b10, 1'b0);
    check(rd_data == 4'hA, "R10 word at zero", int'(rd_data), 10);
    step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b1);
    check(rd_ptr == 12'd8, "R9 rd_ptr passes empty", int'(rd_ptr), 8);
    check(empty == 1'b1, "R9 stays empty", int'(empty), 1);
    for (int i = 2; i < CAP / RA; i++) step(1'b0, '0, 1'b1);
    check(rd_ptr == 12'd0, "R2 read counter wrapped", int'(rd_ptr), 0);
    check(rd_data == 4'hA, "R9 same word again", int'(rd_data), 10);

    // constrained random traffic
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      if (i % 50 == 0) begin
        p   = int'($urandom % 4);
        sof = (p != 0);
        soe = (p != 1);
      end
      if (i % 200 == 0) begin
        af_thr = 12'($urandom % 300);
        ae_thr = 12'($urandom % 300);
      end
      p = int'($urandom % 100);
      step(p < ((i / 500) % 2 == 0 ? 70 : 35), 2'($urandom),
           ($urandom % 100) < ((i / 500) % 2 == 0 ? 35 : 70));
    end
    step(1'b0, '0, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule